// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the DWORD address for every data phase of a 32-bit bus burst, as seen from the target. At the address phase it loads the starting address and interprets the two lowest address bits as a burst ordering code. After each completed data phase it computes the address of the next one. Two orderings are carried out: a plain incrementing sequence, and a cache-line wrap sequence that walks to the end of the line, continues from the line's first DWORD until the whole line has been moved, and then resumes at the starting offset inside the following line.

When the ordering code is one of the two reserved values, or wrap ordering is requested but cannot be honoured (wrap support switched off, or a line size that is not a power of two from 1 to 64 DWORDs), the block raises a flag telling the surrounding target logic to disconnect after the first data phase. The line size and the wrap enable are taken once, at the address phase, so software may reprogram them while a burst is under way without disturbing it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low) cur_addr reads 0 and disc_req reads 0.
- R2: A cycle with addr_phase high loads cur_addr with addr_in with bits [1:0] forced to 0, visible after that clock edge; addr_phase takes precedence over a phase_done in the same cycle.
- R3: In a cycle with neither addr_phase nor phase_done high, cur_addr and disc_req keep their values.
- R4: Ordering code addr_in[1:0] = 00 selects linear order: each phase_done adds 4 to cur_addr, modulo 2^ADDR_W, and disc_req is 0.
- R5: Ordering codes 01 and 11 are reserved: disc_req is 1 from the edge after the address phase until the next address phase, and cur_addr still advances by 4 per phase_done.
- R6: Ordering code 10 with wrap_en = 1 and a valid line size (line_dw a power of two, 1 to 64) selects wrap order: within a line the DWORD index steps up by one and rolls from the last DWORD of the line to its first, and disc_req is 0.
- R7: In wrap order, after line_dw phases the next address is the starting offset inside the following line (16-byte line starting at 0x8 gives 0x8, 0xC, 0x0, 0x4, 0x18).
- R8: A wrap-order burst that starts on a line boundary produces the same sequence as linear order.
- R9: Ordering code 10 with wrap_en = 0, or with line_dw equal to 0, not a power of two, or above 64, sets disc_req to 1 and the address advances linearly.
- R10: line_dw and wrap_en are sampled only at the address phase; changing them during a burst does not alter that burst's addresses or disc_req.
- R11: disc_req changes only on the edge that ends an address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_phase | input | 1 | High for the cycle in which addr_in holds the burst's starting address |
| addr_in | input | ADDR_W | Starting byte address; bits [1:0] carry the ordering code |
| phase_done | input | 1 | High for each cycle in which a data phase completes |
| line_dw | input | $clog2(MAX_LINE_DW)+1 | Cache line size in DWORDs |
| wrap_en | input | 1 | Wrap ordering supported when high |
| cur_addr | output | ADDR_W | Byte address of the current data phase, bits [1:0] always 0 |
| disc_req | output | 1 | Disconnect after the first data phase |

## Verification
Every result is registered once: the starting address and the disconnect flag appear after the clock edge that samples addr_phase, and each following address appears after the edge that samples phase_done. The bench drives inputs on the falling edge and compares on the next falling edge, so each comparison lands exactly one rising edge after its stimulus, and idle cycles inserted between phases are compared again to confirm the hold. Expected addresses come from a closed-form formula in the bench (line base, line count and offset modulo the line size), swept over every ordering code, a range of start offsets and line sizes including illegal ones.

// File: rtl/bas_pkg.sv
package bas_pkg;
   typedef enum logic [1:0] {
      BM_LINEAR = 2'd0,
      BM_WRAP   = 2'd1,
      BM_DISC   = 2'd2
   } burst_mode_e;
endpackage

// File: rtl/bas_mode_decode.sv
module bas_mode_decode
   import bas_pkg::*;
#(
   parameter int CNT_W        = 6,
   parameter int MAX_LINE_DW  = 64,
   parameter bit SUPPORT_WRAP = 1'b1
) (
   input  logic [1:0]     code,
   input  logic           wrap_en,
   input  logic [CNT_W:0] line_dw,
   output burst_mode_e    mode,
   output logic [CNT_W-1:0] mask
);
   localparam logic [CNT_W:0] ONE   = {{CNT_W{1'b0}}, 1'b1};
   localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(MAX_LINE_DW);

   logic [CNT_W:0] size_m1;
   logic           size_ok;
   logic           wrap_ok;

   assign size_m1 = line_dw - ONE;
   assign size_ok = (line_dw != '0) && ((line_dw & size_m1) == '0) && (line_dw <= LIMIT);
   assign mask    = size_ok ? size_m1[CNT_W-1:0] : '0;

   generate
      if (SUPPORT_WRAP) begin : g_wrap
         assign wrap_ok = wrap_en && size_ok;
      end else begin : g_nowrap
         assign wrap_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      case (code)
         2'b00:   mode = BM_LINEAR;
         2'b10:   mode = wrap_ok ? BM_WRAP : BM_DISC;
         default: mode = BM_DISC;
      endcase
   end
endmodule

// File: rtl/bas_line_ctr.sv
module bas_line_ctr #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [CNT_W-1:0] mask,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   assign last = (cnt_q == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bas_next_addr.sv
module bas_next_addr
   import bas_pkg::*;
#(
   parameter int DW_W  = 30,
   parameter int CNT_W = 6
) (
   input  logic [DW_W-1:0]  cur_dw,
   input  burst_mode_e      mode,
   input  logic [CNT_W-1:0] mask,
   input  logic [CNT_W-1:0] start_off,
   input  logic             last,
   output logic [DW_W-1:0]  nxt_dw
);
   localparam int PAD = DW_W - CNT_W;

   logic [DW_W-1:0] mask_ext;
   logic [DW_W-1:0] off_ext;
   logic [DW_W-1:0] inc;
   logic [DW_W-1:0] base;

   assign mask_ext = {{PAD{1'b0}}, mask};
   assign off_ext  = {{PAD{1'b0}}, start_off};
   assign inc      = cur_dw + 1'b1;
   assign base     = cur_dw & ~mask_ext;

   always_comb begin
      if (mode == BM_WRAP) begin
         if (last) nxt_dw = base + mask_ext + 1'b1 + off_ext;
         else      nxt_dw = base | (inc & mask_ext);
      end else begin
         nxt_dw = inc;
      end
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int MAX_LINE_DW  = 64,
   parameter bit SUPPORT_WRAP = 1'b1,
   localparam int CNT_W       = $clog2(MAX_LINE_DW),
   localparam int LSZ_W       = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_phase,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              phase_done,
   input  logic [LSZ_W-1:0]  line_dw,
   input  logic              wrap_en,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              disc_req
);
   localparam int DW_W = ADDR_W - 2;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
         $error("burst_addr_seq: ADDR_W must lie in 8..64");
      end
      if (MAX_LINE_DW < 2 || MAX_LINE_DW > 64 || (MAX_LINE_DW & (MAX_LINE_DW - 1)) != 0) begin : g_bad_line
         $error("burst_addr_seq: MAX_LINE_DW must be a power of two in 2..64");
      end
      if (CNT_W >= DW_W) begin : g_bad_ratio
         $error("burst_addr_seq: line larger than address space");
      end
   endgenerate

   burst_mode_e      dec_mode;
   logic [CNT_W-1:0] dec_mask;
   burst_mode_e      mode_q;
   logic [CNT_W-1:0] mask_q;
   logic [CNT_W-1:0] off_q;
   logic [DW_W-1:0]  dw_q;
   logic [DW_W-1:0]  dw_nxt;
   logic             line_last;
   logic             advance;

   bas_mode_decode #(
      .CNT_W(CNT_W), .MAX_LINE_DW(MAX_LINE_DW), .SUPPORT_WRAP(SUPPORT_WRAP)
   ) u_dec (
      .code(addr_in[1:0]), .wrap_en(wrap_en), .line_dw(line_dw),
      .mode(dec_mode), .mask(dec_mask)
   );

   assign advance = phase_done && !addr_phase;

   bas_line_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clear(addr_phase),
      .step(advance && (mode_q == BM_WRAP)),
      .mask(mask_q), .last(line_last)
   );

   bas_next_addr #(.DW_W(DW_W), .CNT_W(CNT_W)) u_nxt (
      .cur_dw(dw_q), .mode(mode_q), .mask(mask_q),
      .start_off(off_q), .last(line_last), .nxt_dw(dw_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dw_q   <= '0;
         mode_q <= BM_LINEAR;
         mask_q <= '0;
         off_q  <= '0;
      end else if (addr_phase) begin
         dw_q   <= addr_in[ADDR_W-1:2];
         mode_q <= dec_mode;
         mask_q <= dec_mask;
         off_q  <= addr_in[CNT_W+1:2] & dec_mask;
      end else if (advance) begin
         dw_q   <= dw_nxt;
      end
   end

   assign cur_addr = {dw_q, 2'b00};
   assign disc_req = (mode_q == BM_DISC);
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
   parameter int ADDR_W      = 32,
   parameter int MAX_LINE_DW = 64,
   localparam int LSZ_W      = $clog2(MAX_LINE_DW) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_phase,
   input logic [ADDR_W-1:0] addr_in,
   input logic              phase_done,
   input logic [LSZ_W-1:0]  line_dw,
   input logic              wrap_en,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              disc_req
);
   logic              ck_armed;
   logic              ck_wrap;
   logic [ADDR_W-1:0] ck_lbytes;
   logic [ADDR_W-1:0] ck_lsz;
   logic [ADDR_W-1:0] ck_cnt;
   logic [ADDR_W-1:0] lsz_in;
   logic              pow2_in;
   logic              adv;

   assign lsz_in  = ADDR_W'(line_dw);
   assign pow2_in = (lsz_in != 0) && ((lsz_in & (lsz_in - 1)) == 0) && (lsz_in <= ADDR_W'(MAX_LINE_DW));
   assign adv     = phase_done && !addr_phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_armed  <= 1'b0;
         ck_wrap   <= 1'b0;
         ck_lsz    <= '0;
         ck_lbytes <= '0;
         ck_cnt    <= '0;
      end else if (addr_phase) begin
         ck_armed  <= 1'b1;
         ck_wrap   <= (addr_in[1:0] == 2'b10) && wrap_en && pow2_in;
         ck_lsz    <= lsz_in;
         ck_lbytes <= (lsz_in << 2) - 1;
         ck_cnt    <= '0;
      end else if (adv && ck_wrap) begin
         ck_cnt <= (ck_cnt == ck_lsz - 1) ? '0 : ck_cnt + 1;
      end
   end

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (cur_addr == '0) && !disc_req);

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      addr_phase |=> cur_addr == {$past(addr_in[ADDR_W-1:2]), 2'b00});

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_phase && !phase_done) |=> $stable(cur_addr) && $stable(disc_req));

   a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_armed && !ck_wrap && adv) |=> cur_addr == $past(cur_addr) + ADDR_W'(4));

   a_r5_reserved_disc: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && addr_in[0]) |=> disc_req);

   a_r6_wrap_in_line: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_wrap && adv && ck_cnt != ck_lsz - 1)
      |=> (cur_addr & ~ck_lbytes) == ($past(cur_addr) & ~$past(ck_lbytes)));

   a_r7_next_line: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_wrap && adv && ck_cnt == ck_lsz - 1)
      |=> (cur_addr & ~ck_lbytes) == (($past(cur_addr) & ~$past(ck_lbytes)) + (ck_lsz << 2)));

   a_r9_nowrap_disc: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && addr_in[1:0] == 2'b10 && !wrap_en) |=> disc_req);

   a_r11_disc_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_phase |=> $stable(disc_req));

   a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cur_addr[1:0] == 2'b00);
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .MAX_LINE_DW(MAX_LINE_DW)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_phase = 1'b0;
   logic [31:0] addr_in = '0;
   logic        phase_done = 1'b0;
   logic [6:0]  line_dw = '0;
   logic        wrap_en = 1'b0;
   logic [31:0] cur_addr;
   logic        disc_req;

   int vectors = 0;
   int fails   = 0;

   always #2 clk = ~clk;

   burst_addr_seq u0 (
      .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .addr_in(addr_in),
      .phase_done(phase_done), .line_dw(line_dw), .wrap_en(wrap_en),
      .cur_addr(cur_addr), .disc_req(disc_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic pow2(input int l);
      return (l >= 1) && (l <= 64) && ((l & (l - 1)) == 0);
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] start, input int n,
                                            input logic wrapv, input int l);
      logic [31:0] dw0, base, off;
      dw0 = start >> 2;
      if (!wrapv) return (dw0 + 32'(n)) << 2;
      off  = dw0 & 32'(l - 1);
      base = dw0 - off;
      return (base + 32'((n / l) * l) + ((off + 32'(n % l)) % 32'(l))) << 2;
   endfunction

   task automatic run_burst(input logic [31:0] start, input int l, input logic wen,
                            input logic overlap, input logic mess);
      logic wrapv, dexp;
      int nph;
      string tag;
      wrapv = (start[1:0] == 2'b10) && wen && pow2(l);
      dexp  = start[0] || ((start[1:0] == 2'b10) && !wrapv);
      if (start[1:0] == 2'b00)      tag = "R4";
      else if (start[0])            tag = "R5";
      else if (!wrapv)              tag = "R9";
      else if ((start[31:2] & 32'(l - 1)) == 0) tag = "R8";
      else                          tag = "R6";
      if (mess) tag = "R10";
      nph = wrapv ? 2 * l + 3 : 6;
      @(negedge clk);
      addr_in = start; addr_phase = 1'b1; line_dw = 7'(l); wrap_en = wen;
      phase_done = overlap;
      @(negedge clk);
      addr_phase = 1'b0; phase_done = 1'b0;
      check("R2", cur_addr, {start[31:2], 2'b00});
      check(mess ? "R10" : (dexp ? "R5" : "R4"), 32'(disc_req), 32'(dexp));
      if (mess) begin line_dw = 7'd3; wrap_en = ~wen; end
      for (int n = 1; n <= nph; n++) begin
         phase_done = 1'b1;
         @(negedge clk);
         phase_done = 1'b0;
         if (wrapv && !mess && (n % l) == 0 && l > 1)
            check("R7", cur_addr, exp_addr(start, n, wrapv, l));
         else
            check(tag, cur_addr, exp_addr(start, n, wrapv, l));
         if (n % 3 == 0) begin
            @(negedge clk);
            check("R3", cur_addr, exp_addr(start, n, wrapv, l));
            check("R11", 32'(disc_req), 32'(dexp));
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int sizes[8] = '{0, 1, 2, 3, 4, 8, 16, 64};
      addr_phase = 1'b1; addr_in = 32'h1234_5678; phase_done = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", cur_addr, 32'h0);
      check("R1", 32'(disc_req), 32'h0);
      addr_phase = 1'b0; phase_done = 1'b0;
      rst_n = 1'b1;

      // Worked example: 16-byte line starting at 0x8
      run_burst(32'h0000_000A, 4, 1'b1, 1'b0, 1'b0);

      for (int code = 0; code < 4; code++)
         for (int off = 0; off < 16; off++)
            for (int s = 0; s < 8; s++)
               for (int w = 0; w < 2; w++)
                  run_burst(32'h00A0_0000 | (32'((off * 7) % 64) << 2) | 32'(code),
                            sizes[s], w[0], off[0], off == 5);

      // Top of address space
      run_burst(32'hFFFF_FFF8, 4, 1'b1, 1'b0, 1'b0);
      run_burst(32'hFFFF_FFFA, 4, 1'b1, 1'b1, 1'b0);
      run_burst(32'hFFFF_FFFA, 128, 1'b1, 1'b0, 1'b0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule